// File: doc/BRIEF.md
# Low-voltage detector sequencing controller

This block is the digital side of a supply-voltage monitor. An analog comparator reports whether the monitored supply is below a programmed threshold. This controller decides when that comparator runs and what happens when it reports a low supply. It picks one of four slow clock sources, given as per-cycle enable pulses, and divides it. It holds a write-protected control register that sets the threshold code, the monitored supply and the operating mode. It also drives the comparator enable and collects the comparator result on each divided-clock tick.

There are two operating modes. In continuous mode the comparator stays enabled, and every low sample raises a request. In intermittent mode the comparator is enabled for one divided-clock period out of a programmable interval. A request is raised only after a programmed number of consecutive low samples: 1, 2, 4 or 8. A key value in the outcome field turns the request into a one-cycle reset request. Any other value sets a sticky interrupt flag, which software clears.

Top module: `lvd_seq_ctrl`

## Requirements
- R1: After reset, all three registers read 0 (address 0 clock configuration, address 1 control, address 2 status), and `cmp_en`, `irq`, `rst_req`, `lvl_sel` and `sup_sel` are low. Control bit 3 always reads 0.
- R2: Writes to address 0 or 1 take effect only in a cycle where `prot_unlock` is high. Otherwise the read-back value does not change.
- R3: The control field bits 11:7 hold the threshold code. A control write whose code is below 0x0C is dropped as a whole. `lvl_sel` drives the stored code, and `sup_sel` drives control bit 4 (0 core supply, 1 external sense pin).
- R4: The clock configuration holds the source in bits 1:0 and the divider code in bits 6:4. Sources 0 and 2 divide their enable pulses by 2^(code+4) for codes 0 to 5. Sources 1 and 3 pass their pulses through 1/1, and only with code 0. A write with any other combination is dropped.
- R5: The count code in control bits 6:5 is updated only if the stored mode field (bits 2:1) is nonzero before the write. The other fields of the same write still apply.
- R6: Control bit 0 enables detection. With mode 1 to 3 (intermittent), `cmp_en` is high for exactly one divided period in every 2^(mode+4) divided periods.
- R7: In intermittent mode, a request is raised on the sample that completes 2^code consecutive low results (`cmp_low` = 1 on an enabled divided tick). A sample that is not low restarts the count.
- R8: In mode 0 (continuous), `cmp_en` stays high while enabled. Every low sample raises a request, whatever the count code.
- R9: When control bits 15:12 equal 0xA, a request gives a one-cycle `rst_req` pulse and leaves `irq` unchanged. Any other value sets the sticky `irq` flag instead.
- R10: Writing 1 to status bit 0 clears `irq`, with no unlock needed. A request in the same cycle wins over the clear.
- R11: Clearing the enable bit forces `cmp_en` low and discards any partial consecutive-low count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 16 | Write data |
| prot_unlock | input | 1 | Unlocks writes to the protected registers |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| clk_src_en | input | 4 | Per-source clock enable pulses |
| cmp_low | input | 1 | Comparator result, 1 = supply below threshold |
| cmp_en | output | 1 | Comparator enable |
| lvl_sel | output | 5 | Threshold code to the reference |
| sup_sel | output | 1 | Monitored supply select |
| irq | output | 1 | Sticky interrupt request |
| rst_req | output | 1 | One-cycle reset request |

## Verification
A low-voltage request can arrive in the same clock cycle as a software write that clears the interrupt flag. The bench provokes this in continuous mode with the flag already set. It drives `cmp_low` high and a status write of 1 in one cycle, then expects the flag to stay set. A plain clear that follows must drop it. A second collision is also covered. A control write can land in the middle of a consecutive-low run: the bench disables detection partway through a two-sample run and expects the run to start over.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
   localparam int unsigned DATA_W  = 16;
   localparam int unsigned ADDR_W  = 2;
   localparam int unsigned SRC_W   = 2;
   localparam int unsigned DIV_W   = 3;
   localparam int unsigned DIV_LSB = 4;
   localparam int unsigned LVL_W   = 5;
   localparam int unsigned MODE_W  = 2;
   localparam int unsigned CNT_W   = 2;
   localparam int unsigned OUT_W   = 4;

   // control register layout, MSB first
   typedef struct packed {
      logic [OUT_W-1:0]  outcome;   // 15:12
      logic [LVL_W-1:0]  level;     // 11:7
      logic [CNT_W-1:0]  cnt_code;  // 6:5
      logic              sup_sel;   // 4
      logic              rsvd;      // 3
      logic [MODE_W-1:0] mode;      // 2:1
      logic              enable;    // 0
   } ctl_t;

   typedef enum logic [ADDR_W-1:0] {
      ADDR_CLK  = 2'd0,
      ADDR_CTL  = 2'd1,
      ADDR_STAT = 2'd2
   } addr_e;
endpackage

// File: rtl/lvd_regs.sv
module lvd_regs
   import lvd_pkg::*;
#(
   parameter int unsigned        NUM_SRC      = 4,
   parameter logic [NUM_SRC-1:0] FAST_MASK    = 4'b0101,
   parameter int unsigned        DIV_CODE_MAX = 5,
   parameter int unsigned        LVL_MIN      = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              prot_unlock,
   input  logic              flag,
   output logic [DATA_W-1:0] reg_rdata,
   output ctl_t              ctl,
   output logic [SRC_W-1:0]  src_sel,
   output logic [DIV_W-1:0]  div_code,
   output logic              flag_clr
);
   localparam int unsigned CLK_PAD_HI = DATA_W - DIV_LSB - DIV_W;
   localparam int unsigned CLK_PAD_LO = DIV_LSB - SRC_W;

   ctl_t             ctl_q, ctl_d, wr_ctl;
   logic [SRC_W-1:0] src_q, wr_src;
   logic [DIV_W-1:0] div_q, wr_div;
   logic             wr_ok, ctl_wr, clk_wr, lvl_ok, clk_ok;
   logic [NUM_SRC-1:0] div_ok_vec;

   assign wr_ctl = ctl_t'(reg_wdata);
   assign wr_src = reg_wdata[SRC_W-1:0];
   assign wr_div = reg_wdata[DIV_LSB +: DIV_W];
   assign wr_ok  = reg_wr && prot_unlock;

   // per-source legality of the divider code: the mask picks the rule
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_rule
      if (FAST_MASK[s]) begin : g_fast
         assign div_ok_vec[s] = (wr_div <= DIV_W'(DIV_CODE_MAX));
      end else begin : g_slow
         assign div_ok_vec[s] = (wr_div == '0);
      end
   end

   assign clk_ok = div_ok_vec[wr_src];
   assign lvl_ok = (wr_ctl.level >= LVL_W'(LVL_MIN));
   assign ctl_wr = wr_ok && (reg_addr == ADDR_CTL) && lvl_ok;
   assign clk_wr = wr_ok && (reg_addr == ADDR_CLK) && clk_ok;

   always_comb begin
      ctl_d      = wr_ctl;
      ctl_d.rsvd = 1'b0;
      if (ctl_q.mode == '0) begin
         ctl_d.cnt_code = ctl_q.cnt_code;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         src_q <= '0;
         div_q <= '0;
      end else begin
         if (ctl_wr) begin
            ctl_q <= ctl_d;
         end
         if (clk_wr) begin
            src_q <= wr_src;
            div_q <= wr_div;
         end
      end
   end

   assign flag_clr = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[0];

   always_comb begin
      unique case (reg_addr)
         ADDR_CLK:  reg_rdata = {{CLK_PAD_HI{1'b0}}, div_q, {CLK_PAD_LO{1'b0}}, src_q};
         ADDR_CTL:  reg_rdata = DATA_W'(ctl_q);
         ADDR_STAT: reg_rdata = {{(DATA_W-1){1'b0}}, flag};
         default:   reg_rdata = '0;
      endcase
   end

   assign ctl      = ctl_q;
   assign src_sel  = src_q;
   assign div_code = div_q;

   a_r2_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !prot_unlock) |=> ($stable(ctl_q) && $stable(src_q) && $stable(div_q)));

   a_r3_level_floor: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctl_q.level) |-> (ctl_q.level >= LVL_W'(LVL_MIN)));

   a_r4_div_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(div_q) || !$stable(src_q)) |->
         (FAST_MASK[src_q] ? (div_q <= DIV_W'(DIV_CODE_MAX)) : (div_q == '0)));

   a_r5_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_CTL && ctl_q.mode == '0) |=> $stable(ctl_q.cnt_code));

   a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q.rsvd == 1'b0);
endmodule

// File: rtl/lvd_clkdiv.sv
module lvd_clkdiv
   import lvd_pkg::*;
#(
   parameter int unsigned        NUM_SRC      = 4,
   parameter logic [NUM_SRC-1:0] FAST_MASK    = 4'b0101,
   parameter int unsigned        DIV_BASE_LOG = 4,
   parameter int unsigned        DCNT_W       = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic [SRC_W-1:0]   src_sel,
   input  logic [DIV_W-1:0]   div_code,
   output logic               div_tick
);
   logic [NUM_SRC-1:0] tick_gated;
   logic [NUM_SRC-1:0] fast_gated;
   logic               tick, fast;
   logic [DCNT_W:0]    span;
   logic [DCNT_W-1:0]  last_cnt, dcnt_q;
   logic               wrap;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_sel
      assign tick_gated[s] = src_tick[s] && (src_sel == SRC_W'(s));
      assign fast_gated[s] = FAST_MASK[s] && (src_sel == SRC_W'(s));
   end

   assign tick = |tick_gated;
   assign fast = |fast_gated;

   assign span     = (DCNT_W+1)'(1) << (DIV_BASE_LOG + 32'(div_code));
   assign last_cnt = fast ? DCNT_W'(span - 1'b1) : '0;
   assign wrap     = (dcnt_q >= last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt_q <= '0;
      end else if (tick) begin
         dcnt_q <= wrap ? '0 : dcnt_q + 1'b1;
      end
   end

   assign div_tick = tick && wrap;

   a_r4_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !src_tick[src_sel] |-> !div_tick);

   a_r4_counter_parks: assert property (@(posedge clk) disable iff (!rst_n)
      div_tick |=> (dcnt_q == '0));
endmodule

// File: rtl/lvd_seq.sv
module lvd_seq
   import lvd_pkg::*;
#(
   parameter int unsigned    INT_BASE_LOG = 4,
   parameter int unsigned    IC_W         = 7,
   parameter int unsigned    RUN_W        = 4,
   parameter logic [OUT_W-1:0] RST_KEY    = 4'hA
) (
   input  logic clk,
   input  logic rst_n,
   input  ctl_t ctl,
   input  logic div_tick,
   input  logic cmp_low,
   input  logic flag_clr,
   output logic cmp_en,
   output logic flag,
   output logic rst_req
);
   logic             enable, intermit, last, sample, hit, key;
   logic [IC_W:0]    int_len;
   logic [IC_W-1:0]  ic_q;
   logic [RUN_W-1:0] run_q, run_inc, need;
   logic             flag_q, rst_q;

   assign enable   = ctl.enable;
   assign intermit = (ctl.mode != '0);
   assign key      = (ctl.outcome == RST_KEY);

   // interval of 2^(mode+base) divided periods
   assign int_len = (IC_W+1)'(1) << (INT_BASE_LOG + 32'(ctl.mode));
   assign last    = (ic_q >= IC_W'(int_len - 1'b1));
   assign cmp_en  = enable && (!intermit || last);
   assign sample  = cmp_en && div_tick;

   assign need    = intermit ? (RUN_W'(1) << ctl.cnt_code) : RUN_W'(1);
   assign run_inc = run_q + 1'b1;
   assign hit     = sample && cmp_low && (run_inc >= need);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ic_q <= '0;
      end else if (!enable || !intermit) begin
         ic_q <= '0;
      end else if (div_tick) begin
         ic_q <= last ? '0 : ic_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (!enable) begin
         run_q <= '0;
      end else if (sample) begin
         if (!cmp_low || hit) begin
            run_q <= '0;
         end else begin
            run_q <= run_inc;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         rst_q  <= 1'b0;
      end else begin
         rst_q <= hit && key;
         if (hit && !key) begin
            flag_q <= 1'b1;
         end else if (flag_clr) begin
            flag_q <= 1'b0;
         end
      end
   end

   assign flag    = flag_q;
   assign rst_req = rst_q;

   a_r11_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (run_q == '0));

   a_r7_high_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && !cmp_low) |=> (run_q == '0));

   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !key) |=> flag_q);

   a_r9_key_spares_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && key && !flag_clr) |=> (rst_q && flag_q == $past(flag_q)));

   a_r8_continuous_on: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !intermit) |-> cmp_en);
endmodule

// File: rtl/lvd_seq_ctrl.sv
module lvd_seq_ctrl
   import lvd_pkg::*;
#(
   parameter int unsigned        NUM_SRC      = 4,
   parameter logic [NUM_SRC-1:0] FAST_MASK    = 4'b0101,
   parameter int unsigned        DIV_CODE_MAX = 5,
   parameter int unsigned        DIV_BASE_LOG = 4,
   parameter int unsigned        INT_BASE_LOG = 4,
   parameter int unsigned        LVL_MIN      = 12,
   parameter logic [OUT_W-1:0]   RST_KEY      = 4'hA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              prot_unlock,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_SRC-1:0] clk_src_en,
   input  logic              cmp_low,
   output logic              cmp_en,
   output logic [LVL_W-1:0]  lvl_sel,
   output logic              sup_sel,
   output logic              irq,
   output logic              rst_req
);
   localparam int unsigned DCNT_W = DIV_BASE_LOG + DIV_CODE_MAX;
   localparam int unsigned IC_W   = INT_BASE_LOG + (1 << MODE_W) - 1;
   localparam int unsigned RUN_W  = (1 << CNT_W) - 1 + 1;

   if (NUM_SRC != (1 << SRC_W)) begin : g_chk_src
      $error("source count must fill the select field");
   end
   if (LVL_MIN >= (1 << LVL_W)) begin : g_chk_lvl
      $error("level floor exceeds the level field");
   end
   if (DIV_CODE_MAX >= (1 << DIV_W)) begin : g_chk_div
      $error("divider code limit exceeds the divider field");
   end
   if (DCNT_W > 16) begin : g_chk_dcnt
      $error("divider counter too wide");
   end

   ctl_t             ctl;
   logic [SRC_W-1:0] src_sel;
   logic [DIV_W-1:0] div_code;
   logic             flag, flag_clr, div_tick;

   lvd_regs #(
      .NUM_SRC      (NUM_SRC),
      .FAST_MASK    (FAST_MASK),
      .DIV_CODE_MAX (DIV_CODE_MAX),
      .LVL_MIN      (LVL_MIN)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr      (reg_wr),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .prot_unlock (prot_unlock),
      .flag        (flag),
      .reg_rdata   (reg_rdata),
      .ctl         (ctl),
      .src_sel     (src_sel),
      .div_code    (div_code),
      .flag_clr    (flag_clr)
   );

   lvd_clkdiv #(
      .NUM_SRC      (NUM_SRC),
      .FAST_MASK    (FAST_MASK),
      .DIV_BASE_LOG (DIV_BASE_LOG),
      .DCNT_W       (DCNT_W)
   ) u_clkdiv (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (clk_src_en),
      .src_sel  (src_sel),
      .div_code (div_code),
      .div_tick (div_tick)
   );

   lvd_seq #(
      .INT_BASE_LOG (INT_BASE_LOG),
      .IC_W         (IC_W),
      .RUN_W        (RUN_W),
      .RST_KEY      (RST_KEY)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl      (ctl),
      .div_tick (div_tick),
      .cmp_low  (cmp_low),
      .flag_clr (flag_clr),
      .cmp_en   (cmp_en),
      .flag     (flag),
      .rst_req  (rst_req)
   );

   assign lvl_sel = ctl.level;
   assign sup_sel = ctl.sup_sel;
   assign irq     = flag;
endmodule

// File: tb/lvd_seq_ctrl_bench.sv
module lvd_seq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic        prot_unlock = 1'b0;
   logic [15:0] reg_rdata;
   logic [3:0]  clk_src_en = 4'd0;
   logic        cmp_low = 1'b0;
   logic        cmp_en;
   logic [4:0]  lvl_sel;
   logic        sup_sel;
   logic        irq;
   logic        rst_req;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   lvd_seq_ctrl u_lvd_seq_ctrl (
      .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
      .reg_wdata (reg_wdata), .prot_unlock (prot_unlock), .reg_rdata (reg_rdata),
      .clk_src_en (clk_src_en), .cmp_low (cmp_low), .cmp_en (cmp_en),
      .lvl_sel (lvl_sel), .sup_sel (sup_sel), .irq (irq), .rst_req (rst_req)
   );

   // control word builder: outcome[15:12] level[11:7] cnt[6:5] sup[4] mode[2:1] en[0]
   function automatic logic [15:0] cw(input int oc, input int lvl, input int cnt,
                                      input int sup, input int mode, input int en);
      return 16'((oc << 12) | (lvl << 7) | (cnt << 5) | (sup << 4) | (mode << 1) | en);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic unl);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; prot_unlock = unl;
      @(negedge clk);
      reg_wr = 1'b0; prot_unlock = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [1:0] a, input logic [15:0] exp);
      reg_addr = a;
      #1;
      check(tag, 32'(reg_rdata), 32'(exp));
   endtask

   task automatic sample(input logic v);
      @(negedge clk);
      while (!cmp_en) @(negedge clk);
      cmp_low = v;
      @(negedge clk);
      cmp_low = 1'b0;
   endtask

   task automatic measure(output int hi, output int per);
      @(negedge clk);
      while (cmp_en) @(negedge clk);
      while (!cmp_en) @(negedge clk);
      hi = 0;
      while (cmp_en) begin hi++; @(negedge clk); end
      per = hi;
      while (!cmp_en) begin per++; @(negedge clk); end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int hi, per, cnt_hi;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd("R1 clock cfg", 2'd0, 16'h0);
      rd("R1 control", 2'd1, 16'h0);
      rd("R1 status", 2'd2, 16'h0);
      check("R1 outputs", {27'd0, cmp_en, irq, rst_req, sup_sel, |lvl_sel}, 32'd0);

      // R2 protection
      wr(2'd1, cw(0, 12, 0, 1, 1, 0), 1'b0);
      rd("R2 locked control", 2'd1, 16'h0);
      wr(2'd0, 16'h0001, 1'b0);
      rd("R2 locked clock cfg", 2'd0, 16'h0);

      // R3 level floor, reserved bit, outputs
      wr(2'd1, cw(0, 11, 0, 1, 0, 0), 1'b1);
      rd("R3 prohibited level dropped", 2'd1, 16'h0);
      wr(2'd1, cw(0, 12, 0, 1, 0, 0) | 16'h0008, 1'b1);
      rd("R3 R1 valid level, bit 3 reads 0", 2'd1, cw(0, 12, 0, 1, 0, 0));
      check("R3 lvl_sel", 32'(lvl_sel), 32'd12);
      check("R3 sup_sel", 32'(sup_sel), 32'd1);

      // R4 illegal clock configurations
      wr(2'd0, 16'h0031, 1'b1);
      rd("R4 slow source nonzero code dropped", 2'd0, 16'h0);
      wr(2'd0, 16'h0060, 1'b1);
      rd("R4 reserved code dropped", 2'd0, 16'h0);
      wr(2'd0, 16'h0001, 1'b1);
      rd("R4 slow source accepted", 2'd0, 16'h0001);

      // R5 count field gated by stored mode
      wr(2'd1, cw(0, 12, 3, 1, 0, 0), 1'b1);
      rd("R5 count ignored in mode 0", 2'd1, cw(0, 12, 0, 1, 0, 0));
      wr(2'd1, cw(0, 12, 0, 1, 1, 0), 1'b1);
      wr(2'd1, cw(0, 12, 3, 1, 1, 0), 1'b1);
      rd("R5 count accepted", 2'd1, cw(0, 12, 3, 1, 1, 0));

      // R6 intermittent timing with 1/1 source
      clk_src_en = 4'b0010;
      wr(2'd1, cw(0, 12, 3, 1, 1, 1), 1'b1);
      measure(hi, per);
      check("R6 mode 1 width", 32'(hi), 32'd1);
      check("R6 mode 1 interval", 32'(per), 32'd32);
      wr(2'd1, cw(0, 12, 3, 1, 3, 1), 1'b1);
      measure(hi, per);
      check("R6 mode 3 interval", 32'(per), 32'd128);

      // R7 consecutive-count sweep in mode 1
      for (int c = 0; c < 4; c++) begin
         int need;
         need = 1 << c;
         wr(2'd1, cw(0, 12, c, 1, 1, 1), 1'b1);
         wr(2'd2, 16'h0001, 1'b0);
         if (need > 1) sample(1'b1);
         sample(1'b0);
         check("R7 not-low restarts", 32'(irq), 32'd0);
         for (int k = 1; k < need; k++) begin
            sample(1'b1);
            check("R7 below count", 32'(irq), 32'd0);
         end
         sample(1'b1);
         check("R7 count reached", 32'(irq), 32'd1);
      end
      wr(2'd2, 16'h0001, 1'b0);
      check("R10 clear without unlock", 32'(irq), 32'd0);

      // R8 continuous ignores count code 3
      wr(2'd1, cw(0, 12, 3, 1, 0, 1), 1'b1);
      cnt_hi = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (cmp_en) cnt_hi++; end
      check("R8 cmp_en held", 32'(cnt_hi), 32'd20);
      sample(1'b1);
      check("R8 single low raises", 32'(irq), 32'd1);

      // R10 clear and request in the same cycle
      @(negedge clk);
      cmp_low = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0001;
      @(negedge clk);
      cmp_low = 1'b0; reg_wr = 1'b0;
      check("R10 set wins over clear", 32'(irq), 32'd1);
      wr(2'd2, 16'h0001, 1'b0);
      check("R10 clear alone", 32'(irq), 32'd0);

      // R9 reset outcome key
      wr(2'd1, cw(10, 12, 3, 1, 0, 1), 1'b1);
      sample(1'b1);
      check("R9 rst_req pulse", 32'(rst_req), 32'd1);
      check("R9 irq untouched", 32'(irq), 32'd0);
      @(negedge clk);
      check("R9 pulse one cycle", 32'(rst_req), 32'd0);

      // R11 disable discards partial run (need 2)
      wr(2'd1, cw(0, 12, 1, 1, 1, 1), 1'b1);
      sample(1'b1);
      wr(2'd1, cw(0, 12, 1, 1, 1, 0), 1'b1);
      cnt_hi = 0;
      for (int k = 0; k < 40; k++) begin @(negedge clk); if (cmp_en) cnt_hi++; end
      check("R11 cmp_en off", 32'(cnt_hi), 32'd0);
      wr(2'd1, cw(0, 12, 1, 1, 1, 1), 1'b1);
      sample(1'b1);
      check("R11 run restarted", 32'(irq), 32'd0);
      sample(1'b1);
      check("R11 second low completes", 32'(irq), 32'd1);
      wr(2'd2, 16'h0001, 1'b0);

      // R4 divider sweep on source 0, mode 1 (interval 32)
      clk_src_en = 4'b0001;
      wr(2'd1, cw(0, 12, 0, 1, 1, 1), 1'b1);
      for (int d = 0; d < 6; d++) begin
         wr(2'd0, 16'(d << 4), 1'b1);
         measure(hi, per);
         check("R4 R6 divided width", 32'(hi), 32'(16 << d));
         check("R4 divided interval", 32'(per), 32'(512 << d));
      end
      clk_src_en = 4'b0100;
      wr(2'd0, 16'h0002, 1'b1);
      measure(hi, per);
      check("R4 source 2 interval", 32'(per), 32'd512);
      clk_src_en = 4'b1000;
      wr(2'd0, 16'h0003, 1'b1);
      measure(hi, per);
      check("R4 source 3 interval", 32'(per), 32'd32);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule